// File: doc/BRIEF.md
# Signed 4-bit sign-magnitude array multiplier

This block multiplies two small two's complement operands with no clock. The answer is a two's complement product twice as wide as the operands. It first takes the result sign from the operand sign bits. It then reduces each operand to an unsigned magnitude. One extra magnitude bit holds the case where the operand is the most negative value. An AND-gate array forms the partial products. A chain of row adders sums these rows, one row per adder. At the end the unsigned magnitude is negated across the full product width when the result sign is negative.

The default operand width is 4 bits, so the product is 8 bits. The width is a parameter and must be at least 2. Because the final negation spans every product bit, a zero magnitude always gives an all-zero output, whatever the operand signs are.

Top module: `sm_array_mul`

## Requirements
- R1: For every pair of W-bit two's complement operands, p_o equals the signed product a_i × b_i as a 2W-bit two's complement value.
- R2: When the product is nonzero, p_o[2W-1] equals a_i[W-1] XOR b_i[W-1], where 1 means negative.
- R3: When either operand is zero, p_o is all zeros even if the operand signs differ. For example, 0 × -3 gives 0x00 and no -2^(2W-1) appears.
- R4: For the most negative operand with W=4: -8 × -8 gives 0x40 (+64), -8 × 7 gives 0xC8 (-56), and -8 × 1 gives 0xF8 (-8).
- R5: Each operand is taken to its absolute value with one extra magnitude bit, so -8 has magnitude 8. With W=4, -8 × -1 gives 0x08 and -1 × -1 gives 0x01.
- R6: p_o[0] equals a_i[0] AND b_i[0].
- R7: The absolute value of the product never exceeds 2^(2W-2), which is 64 for W=4.
- R8: The block holds no state. p_o depends only on the present a_i and b_i and settles within the same time step as an input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Multiplicand, two's complement |
| b_i | input | W | Multiplier, two's complement |
| p_o | output | 2W | Product, two's complement |

## Verification
Every result is due combinationally: there is no register between a_i/b_i and p_o, so p_o is due zero cycles after a stimulus. The bench drives a new operand pair just after a rising edge of its pacing clock. It samples p_o 2 ns later, well inside the same cycle and away from both clock edges. No check ever waits for a later edge. All 256 pairs are covered exhaustively, followed by seeded random pairs and directed most-negative and zero cases. The operand order is swapped on the most-negative cases (R4).

// File: rtl/smul_pkg.sv
package smul_pkg;
  parameter int unsigned SMUL_W_DEF = 4;
endpackage

// File: rtl/cond_negate.sv
// out = neg ? -in : in, ripple form; carry_o is the bit above out_o
module cond_negate #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] in_i,
  input  logic         neg_i,
  output logic [N-1:0] out_o,
  output logic         carry_o
);
  logic [N:0] c;
  assign c[0] = neg_i;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic x;
    assign x        = in_i[i] ^ neg_i;
    assign out_o[i] = x ^ c[i];
    assign c[i+1]   = x & c[i];
  end

  assign carry_o = c[N];

  always_comb begin
    if (!$isunknown({neg_i, in_i})) begin
      // R5
      neg_value_chk: assert ({carry_o, out_o} ==
        (neg_i ? ({1'b1, {N{1'b0}}} - {1'b0, in_i}) : {1'b0, in_i}))
        else $error("cond_negate value mismatch");
    end
  end
endmodule

// File: rtl/ripple_add.sv
module ripple_add #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  logic [N:0] c;
  assign c[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end

  assign cout_o = c[N];

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      // R1
      row_sum_chk: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}))
        else $error("row adder sum mismatch");
    end
  end
endmodule

// File: rtl/sm_array_mul.sv
module sm_array_mul
  import smul_pkg::*;
#(
  parameter int unsigned W = SMUL_W_DEF
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int unsigned PW = 2 * W;

  logic a_s, b_s, p_s;
  assign a_s = a_i[W-1];
  assign b_s = b_i[W-1];
  assign p_s = a_s ^ b_s;

  // magnitudes: low bits negated, carry out is the extra top bit
  logic [W-1:0] a_mag, b_mag;
  cond_negate #(.N(W-1)) u_abs_a (
    .in_i(a_i[W-2:0]), .neg_i(a_s), .out_o(a_mag[W-2:0]), .carry_o(a_mag[W-1])
  );
  cond_negate #(.N(W-1)) u_abs_b (
    .in_i(b_i[W-2:0]), .neg_i(b_s), .out_o(b_mag[W-2:0]), .carry_o(b_mag[W-1])
  );

  logic [W-1:0] pp [W];
  for (genvar j = 0; j < W; j++) begin : g_pp
    assign pp[j] = a_mag & {W{b_mag[j]}};
  end

  // row chain: low sum bit retires, {carry, upper sum} feeds next row
  logic [W-1:0]  upper [W];
  logic [W-1:0]  rsum  [1:W-1];
  logic          rcarry[1:W-1];
  logic [PW-1:0] mag_prod;

  assign upper[0]    = {1'b0, pp[0][W-1:1]};
  assign mag_prod[0] = pp[0][0];

  for (genvar j = 1; j < W; j++) begin : g_row
    ripple_add #(.N(W)) u_row (
      .a_i(upper[j-1]), .b_i(pp[j]), .sum_o(rsum[j]), .cout_o(rcarry[j])
    );
    assign mag_prod[j] = rsum[j][0];
    assign upper[j]    = {rcarry[j], rsum[j][W-1:1]};
  end

  assign mag_prod[PW-1:W] = upper[W-1];

  // negate over the full width so a zero magnitude stays zero
  logic p_carry;
  cond_negate #(.N(PW)) u_neg_p (
    .in_i(mag_prod), .neg_i(p_s), .out_o(p_o), .carry_o(p_carry)
  );

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      // R1
      mag_prod_chk: assert (mag_prod == (PW'(a_mag) * PW'(b_mag)))
        else $error("magnitude product mismatch");
      // R2
      sign_bit_chk: assert (mag_prod == '0 || p_o[PW-1] == p_s)
        else $error("product sign mismatch");
      // R3
      zero_prod_chk: assert (mag_prod != '0 || p_o == '0)
        else $error("zero product not all zeros");
      // R3
      neg_carry_chk: assert (p_carry == (p_s && mag_prod == '0))
        else $error("final negate carry unexpected");
      // R6
      lsb_chk: assert (p_o[0] == (a_i[0] & b_i[0]))
        else $error("product lsb mismatch");
      // R7
      mag_bound_chk: assert (mag_prod <= (PW'(1) << (PW - 2)))
        else $error("magnitude out of range");
    end
  end
endmodule

// File: tb/tb_sm_array_mul.sv
`timescale 1ns/1ps
module tb_sm_array_mul;
  localparam int W  = 4;
  localparam int PW = 2 * W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0]  a, b;
  logic [PW-1:0] p;

  sm_array_mul #(.W(W)) dut (.a_i(a), .b_i(b), .p_o(p));

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  function automatic int sval(input logic [W-1:0] v);
    return int'(v) - (v[W-1] ? (1 << W) : 0);
  endfunction

  function automatic logic [PW-1:0] exp_prod(input logic [W-1:0] x, input logic [W-1:0] y);
    int s;
    s = sval(x) * sval(y);
    return PW'(s);
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, a, b, act, exp);
    end
  endtask

  // drive after a rising edge, sample 2 ns later (R8: same time step result)
  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [PW-1:0] e;
    int s, m;
    @(posedge clk);
    a = x; b = y;
    #2;
    e = exp_prod(x, y);
    s = sval(x) * sval(y);
    m = (s < 0) ? -s : s;
    check(p === e, "R1 product", p, e);
    if (s != 0)
      check(p[PW-1] == (x[W-1] ^ y[W-1]), "R2 sign", PW'(p[PW-1]), PW'(x[W-1] ^ y[W-1]));
    else
      check(p == '0, "R3 zero", p, '0);
    check(p[0] == (x[0] & y[0]), "R6 lsb", PW'(p[0]), PW'(x[0] & y[0]));
    check(m <= (1 << (PW - 2)), "R7 bound", PW'(m), PW'(1 << (PW - 2)));
  endtask

  task automatic directed(input logic [W-1:0] x, input logic [W-1:0] y,
                          input logic [PW-1:0] e, input string req);
    @(posedge clk);
    a = x; b = y;
    #2;
    check(p === e, req, p, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    a = '0; b = '0;
    #1;
    check(p == '0, "R8 initial zero inputs", p, '0);

    // R4 most negative operand, both orders
    directed(4'h8, 4'h8, 8'h40, "R4 -8*-8");
    directed(4'h8, 4'h7, 8'hC8, "R4 -8*7");
    directed(4'h7, 4'h8, 8'hC8, "R4 7*-8");
    directed(4'h8, 4'h1, 8'hF8, "R4 -8*1");
    // R5 magnitude of negatives
    directed(4'h8, 4'hF, 8'h08, "R5 -8*-1");
    directed(4'hF, 4'hF, 8'h01, "R5 -1*-1");
    directed(4'hB, 4'h4, 8'hEC, "R5 -5*4");
    // R3 zero with differing signs
    directed(4'h0, 4'hD, 8'h00, "R3 0*-3");
    directed(4'h8, 4'h0, 8'h00, "R3 -8*0");

    // R1 exhaustive
    for (int i = 0; i < (1 << W); i++)
      for (int j = 0; j < (1 << W); j++)
        apply(W'(i), W'(j));

    // R1 seeded random, R8 no history: repeat pairs in new order
    void'($urandom(32'd2024));
    for (int k = 0; k < 200; k++)
      apply(W'($urandom()), W'($urandom()));

    finish_run();
  end
endmodule